// File: doc/BRIEF.md
# I2C-Controlled Eight-Pin GPIO Expander

This block is an I2C target that gives a bus controller access to an eight-pin bidirectional port. Four byte-wide registers sit behind the bus: a read-only view of the pin levels, the drive values, a per-pin polarity mask for the pin view, and the per-pin direction. SCL and SDA are sampled with the system clock, so that clock must run well above the bus bit rate. START, repeated START and STOP conditions are found by looking for edges on the sampled lines. A synchronous reset takes the place of a power-on reset.

A transfer opens with a 7-bit address. In a write, the first data byte selects a register, and any further bytes in the same write are stored into that register. A read returns the selected register, as many times as the controller keeps acknowledging. The selection stays in place from one transfer to the next.

On the port side, the block gives a drive value and a drive enable for every pin, and it samples the pin levels through a synchronizer. The bus has no stream interface and no back-pressure, because the block never stretches the clock. The controller alone sets the pace on SCL.

Top module: `gpio_expander_i2c`

## Requirements
- R1: The target pulls SDA low starting at the SCL falling edge that ends the eighth bit of a byte it acknowledges. It keeps SDA low through the high phase of the ninth clock, and releases it at the ninth falling edge. It only starts to pull SDA low while SCL is low.
- R2: The target acknowledges an address byte only when its upper seven bits equal TARGET_ADDR. After any other address it leaves SDA released and ignores the rest of the transfer.
- R3: In a write, the target acknowledges every byte. The first byte after the address is a register selector with these codes: 0x00 pin view, 0x01 drive values, 0x02 polarity mask, 0x03 direction.
- R4: In a read, the target sends bits MSB first. After each byte it releases SDA and samples the controller's acknowledge. An ACK (SDA low) makes it send another byte. A NACK makes it stop driving SDA until the next START or STOP.
- R5: The selector is kept from one transfer to the next. Reads without an intervening selector write keep returning the same register, with no auto-increment.
- R6: Reading selector 0x00 returns the synchronized pin levels XOR the polarity mask. The block takes this value once, at the start of each read byte, and holds it for the whole byte. Writes to 0x00 are acknowledged but change nothing.
- R7: After reset, the drive values are 0x00, the polarity mask is 0xF0, the direction is 0xFF and the selector is 0x00. As a result pin_oe = 0x00 and pin_o = 0x00.
- R8: A direction bit of 1 turns the pin's driver off (pin_oe bit 0). A 0 turns it on (pin_oe bit 1).
- R9: pin_o always equals the stored drive values, whatever the direction. Reading selector 0x01 returns the stored value, not the pin level.
- R10: Selector values above 0x03 are acknowledged. Data bytes written to them change no register, and reads from them return 0x00.
- R11: A START or STOP that arrives in the middle of a byte cancels that byte. A START restarts address matching and a STOP returns the target to idle. Either one releases SDA.
- R12: Every data byte after the selector in one write is stored into the selected register, so the last one written wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| pin_i | input | 8 | Port pin levels |
| pin_o | output | 8 | Port drive values |
| pin_oe | output | 8 | Port drive enables, 1 = driven |

## Verification
The bench builds the block with TARGET_ADDR = 0x5A and SYNC_STAGES = 3. This address has both ones and zeros in its bits, so flipping its least significant bit tests the address comparison. The deeper synchronizer makes every decision wait one cycle longer, yet each one must still land inside a quarter bit period. Across the run, the pin pattern changes in the middle of a read byte, each selector code is written and read, and START and STOP arrive part-way through bytes.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_ADDR,
    LS_ACK,
    LS_WR,
    LS_RD,
    LS_RDACK
  } link_st_e;

  localparam byte_t SEL_PINS = 8'h00;
  localparam byte_t SEL_DRV  = 8'h01;
  localparam byte_t SEL_POL  = 8'h02;
  localparam byte_t SEL_DIR  = 8'h03;

  localparam byte_t INIT_DRV = 8'h00;
  localparam byte_t INIT_POL = 8'hF0;
  localparam byte_t INIT_DIR = 8'hFF;
endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gx_bus_sync.sv
module gx_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_e,
  output logic stop_e
);
  logic [1:0] line_s;
  logic       scl_s;
  logic       scl_q;
  logic       sda_q;

  gx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (line_s)
  );

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_e  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_e   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/gx_regs.sv
module gx_regs
  import gx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  byte_t pin_i,
  input  logic  wr_en,
  input  byte_t wr_sel,
  input  byte_t wr_data,
  input  byte_t rd_sel,
  output byte_t rd_data,
  output byte_t pin_o,
  output byte_t pin_oe
);
  byte_t pins_s;
  byte_t drv_q;
  byte_t pol_q;
  byte_t dir_q;

  gx_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_i),
    .q   (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= INIT_DRV;
      pol_q <= INIT_POL;
      dir_q <= INIT_DIR;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_DRV: drv_q <= wr_data;
        SEL_POL: pol_q <= wr_data;
        SEL_DIR: dir_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_PINS: rd_data = pins_s ^ pol_q;
      SEL_DRV:  rd_data = drv_q;
      SEL_POL:  rd_data = pol_q;
      SEL_DIR:  rd_data = dir_q;
      default:  rd_data = '0;
    endcase
  end

  for (genvar b = 0; b < BYTE_W; b++) begin : g_pin
    assign pin_o[b]  = drv_q[b];
    assign pin_oe[b] = ~dir_q[b];
  end
endmodule

// File: rtl/gx_link.sv
module gx_link
  import gx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h20
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  sda_s,
  input  logic  scl_rise,
  input  logic  scl_fall,
  input  logic  start_e,
  input  logic  stop_e,
  input  byte_t rd_data,
  output logic  sda_drv,
  output byte_t sel,
  output logic  wr_en,
  output byte_t wr_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  link_st_e         st;
  logic [CNT_W-1:0] cnt;
  byte_t            sh;
  byte_t            tx;
  logic             rd_mode;
  logic             first;
  logic             ctl_ack;

  assign wr_data = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= LS_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      rd_mode <= 1'b0;
      first   <= 1'b0;
      ctl_ack <= 1'b0;
      sda_drv <= 1'b0;
      sel     <= SEL_PINS;
      wr_en   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_e) begin
        st      <= LS_ADDR;
        cnt     <= '0;
        sda_drv <= 1'b0;
      end else if (stop_e) begin
        st      <= LS_IDLE;
        sda_drv <= 1'b0;
      end else begin
        case (st)
          LS_ADDR, LS_WR: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (st == LS_ADDR) begin
                if (sh[BYTE_W-1:1] == TARGET_ADDR) begin
                  sda_drv <= 1'b1;
                  rd_mode <= sh[0];
                  first   <= 1'b1;
                  st      <= LS_ACK;
                end else begin
                  st <= LS_IDLE;
                end
              end else begin
                sda_drv <= 1'b1;
                st      <= LS_ACK;
                if (first) begin
                  sel   <= sh;
                  first <= 1'b0;
                end else begin
                  wr_en <= 1'b1;
                end
              end
            end
          end
          LS_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_mode) begin
                st      <= LS_RD;
                tx      <= rd_data;
                sda_drv <= ~rd_data[BYTE_W-1];
              end else begin
                st      <= LS_WR;
                sda_drv <= 1'b0;
              end
            end
          end
          LS_RD: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                st      <= LS_RDACK;
                sda_drv <= 1'b0;
              end else begin
                tx      <= {tx[BYTE_W-2:0], 1'b0};
                sda_drv <= ~tx[BYTE_W-2];
                cnt     <= cnt + 1'b1;
              end
            end
          end
          LS_RDACK: begin
            if (scl_rise) begin
              ctl_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (ctl_ack) begin
                st      <= LS_RD;
                cnt     <= '0;
                tx      <= rd_data;
                sda_drv <= ~rd_data[BYTE_W-1];
              end else begin
                st <= LS_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_expander_i2c.sv
module gpio_expander_i2c
  import gx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [BYTE_W-1:0] pin_i,
  output logic [BYTE_W-1:0] pin_o,
  output logic [BYTE_W-1:0] pin_oe
);
  logic  sda_s;
  logic  scl_rise;
  logic  scl_fall;
  logic  start_e;
  logic  stop_e;
  byte_t rd_data;
  byte_t sel;
  logic  wr_en;
  byte_t wr_data;

  gx_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_e  (start_e),
    .stop_e   (stop_e)
  );

  gx_link #(.TARGET_ADDR(TARGET_ADDR)) u_link (
    .clk      (clk),
    .rst      (rst),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_e  (start_e),
    .stop_e   (stop_e),
    .rd_data  (rd_data),
    .sda_drv  (sda_oe),
    .sel      (sel),
    .wr_en    (wr_en),
    .wr_data  (wr_data)
  );

  gx_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (pin_i),
    .wr_en   (wr_en),
    .wr_sel  (sel),
    .wr_data (wr_data),
    .rd_sel  (sel),
    .rd_data (rd_data),
    .pin_o   (pin_o),
    .pin_oe  (pin_oe)
  );
endmodule

// File: rtl/gx_chk.sv
module gx_chk
  import gx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [BYTE_W-1:0] pin_o,
  input logic [BYTE_W-1:0] pin_oe,
  input logic              start_e,
  input logic              stop_e
);
  // R1
  sda_drive_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R7
  reset_port_state_chk: assert property (@(posedge clk)
    $fell(rst) |-> (pin_oe == '0 && pin_o == '0));

  // R8
  dir_change_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_oe) |-> sda_oe);

  // R12
  drv_change_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_o) |-> sda_oe);

  // R11
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_e |=> !sda_oe);

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_e |=> !sda_oe);
endmodule

bind gpio_expander_i2c gx_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .scl_i   (scl_i),
  .sda_oe  (sda_oe),
  .pin_o   (pin_o),
  .pin_oe  (pin_oe),
  .start_e (start_e),
  .stop_e  (stop_e)
);

// File: tb/test_gpio_expander_i2c.sv
module test_gpio_expander_i2c;
  localparam logic [6:0] ADR = 7'h5A;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [7:0] pins = 8'h00;
  logic       sda_oe;
  logic [7:0] pin_o;
  logic [7:0] pin_oe;
  wire        sda_line = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  gpio_expander_i2c #(.TARGET_ADDR(ADR), .SYNC_STAGES(3)) i_gpio_expander_i2c (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .pin_i  (pins),
    .pin_o  (pin_o),
    .pin_oe (pin_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] v;
    string      req;
  } item_t;
  item_t      exp_q[$];
  logic [7:0] got_q[$];

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        item_t e;
        logic [7:0] g;
        e = exp_q.pop_front();
        g = got_q.pop_front();
        chk(g == e.v, e.req, g, e.v);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      summary();
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq();
    scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq();
    scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic wbit(input logic b);
    m_sda = b; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; wq();
    scl = 1'b1; wq();
    b = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = !b;
  endtask

  task automatic rbyte(input bit mack, input int chg, input logic [7:0] newpins, output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      logic b;
      if (i == chg) pins = newpins;
      rbit(b);
      v[7-i] = b;
    end
    wbit(!mack);
  endtask

  task automatic wr(input logic [7:0] sel, input int n, input logic [7:0] d0, input logic [7:0] d1, input string req);
    bit ack;
    i2c_start();
    wbyte({ADR, 1'b0}, ack);
    chk(ack, "R2", {7'h0, ack}, 8'h01);
    wbyte(sel, ack);
    chk(ack, req, {7'h0, ack}, 8'h01);
    if (n > 0) begin
      wbyte(d0, ack);
      chk(ack, req, {7'h0, ack}, 8'h01);
      chk(sda_oe == 1'b0, "R1", {7'h0, sda_oe}, 8'h00);
    end
    if (n > 1) begin
      wbyte(d1, ack);
      chk(ack, req, {7'h0, ack}, 8'h01);
    end
    i2c_stop();
  endtask

  task automatic rd(input int n);
    bit ack;
    logic [7:0] v;
    i2c_start();
    wbyte({ADR, 1'b1}, ack);
    chk(ack, "R2", {7'h0, ack}, 8'h01);
    for (int k = 0; k < n; k++) begin
      rbyte(k < n - 1, -1, 8'h00, v);
      got_q.push_back(v);
    end
    i2c_stop();
  endtask

  task automatic expect_byte(input logic [7:0] v, input string req);
    item_t e;
    e.v = v;
    e.req = req;
    exp_q.push_back(e);
  endtask

  initial begin
    bit ack;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R7 reset state at the port
    chk(pin_oe == 8'h00, "R7", pin_oe, 8'h00);
    chk(pin_o == 8'h00, "R7", pin_o, 8'h00);
    chk(sda_oe == 1'b0, "R7", {7'h0, sda_oe}, 8'h00);

    // R7 selector resets to pin view; pins 0 ^ mask F0
    expect_byte(8'hF0, "R7");
    rd(1);

    // R7 polarity reset value, R5 sticky selector
    wr(8'h02, 0, 8'h00, 8'h00, "R3");
    expect_byte(8'hF0, "R7");
    rd(1);
    expect_byte(8'hF0, "R5");
    rd(1);

    // R8 direction
    wr(8'h03, 1, 8'h0F, 8'h00, "R3");
    repeat (4) @(negedge clk);
    chk(pin_oe == 8'hF0, "R8", pin_oe, 8'hF0);
    expect_byte(8'h0F, "R3");
    rd(1);

    // R9 drive values read back as stored
    wr(8'h01, 1, 8'hA5, 8'h00, "R3");
    chk(pin_o == 8'hA5, "R9", pin_o, 8'hA5);
    expect_byte(8'hA5, "R9");
    rd(1);

    // R6 pin view and ignored write
    pins = 8'h3C;
    wr(8'h00, 0, 8'h00, 8'h00, "R3");
    expect_byte(8'hCC, "R6");
    rd(1);
    wr(8'h00, 1, 8'hFF, 8'h00, "R6");
    chk(pin_o == 8'hA5 && pin_oe == 8'hF0, "R6", pin_o, 8'hA5);
    expect_byte(8'hCC, "R6");
    rd(1);

    // R6 snapshot held for the byte; R4 burst continues on ACK
    wr(8'h02, 1, 8'h00, 8'h00, "R3");
    wr(8'h00, 0, 8'h00, 8'h00, "R3");
    expect_byte(8'h3C, "R6");
    expect_byte(8'h81, "R4");
    i2c_start();
    wbyte({ADR, 1'b1}, ack);
    chk(ack, "R2", {7'h0, ack}, 8'h01);
    rbyte(1'b1, 3, 8'h81, v);
    got_q.push_back(v);
    rbyte(1'b0, -1, 8'h00, v);
    got_q.push_back(v);
    i2c_stop();

    // R4 NACK leaves the bus released until STOP
    pins = 8'h00;
    i2c_start();
    wbyte({ADR, 1'b1}, ack);
    rbyte(1'b0, -1, 8'h00, v);
    for (int i = 0; i < 9; i++) begin
      logic b;
      rbit(b);
      chk(b == 1'b1, "R4", {7'h0, b}, 8'h01);
    end
    i2c_stop();

    // R2 foreign address not acknowledged, data ignored
    i2c_start();
    wbyte({ADR ^ 7'h01, 1'b0}, ack);
    chk(!ack, "R2", {7'h0, ack}, 8'h00);
    wbyte(8'h01, ack);
    chk(!ack, "R2", {7'h0, ack}, 8'h00);
    wbyte(8'hFF, ack);
    i2c_stop();
    chk(pin_o == 8'hA5, "R2", pin_o, 8'hA5);

    // R10 out-of-range selector
    wr(8'h07, 1, 8'h55, 8'h00, "R10");
    chk(pin_o == 8'hA5 && pin_oe == 8'hF0, "R10", pin_o, 8'hA5);
    expect_byte(8'h00, "R10");
    rd(1);

    // R12 multiple data bytes in one write
    wr(8'h01, 2, 8'h11, 8'h22, "R12");
    chk(pin_o == 8'h22, "R12", pin_o, 8'h22);
    expect_byte(8'h22, "R12");
    rd(1);

    // R11 repeated START mid-address
    i2c_start();
    wbit(ADR[6]); wbit(ADR[5]); wbit(ADR[4]);
    chk(sda_oe == 1'b0, "R11", {7'h0, sda_oe}, 8'h00);
    wr(8'h01, 1, 8'h5C, 8'h00, "R11");
    chk(pin_o == 8'h5C, "R11", pin_o, 8'h5C);

    // R11 STOP mid-data-byte cancels it
    i2c_start();
    wbyte({ADR, 1'b0}, ack);
    wbyte(8'h01, ack);
    wbit(1'b0); wbit(1'b0); wbit(1'b1);
    i2c_stop();
    chk(pin_o == 8'h5C && sda_oe == 1'b0, "R11", pin_o, 8'h5C);
    expect_byte(8'h5C, "R11");
    rd(1);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0 && got_q.size() == 0, "R4", 8'(got_q.size()), 8'(exp_q.size()));
    done = 1;
    summary();
  end
endmodule